// File: doc/BRIEF.md
# HDLC Receive Byte Queue With Packet Boundary Events

This block sits between a bit-level HDLC receiver and a host that unloads received packets one byte at a time. The receiver writes a byte together with a flag that marks the last byte of a packet. The host pulls bytes from the head of the queue and gets each byte back with that flag. The queue holds 32 entries. Each entry is 9 bits wide: an 8-bit data byte and a 1-bit end-of-packet flag.

Alongside the data path, the block raises four single-cycle event pulses. Together they let a host service packets without polling the fill level. The first pulse fires when the queue fill climbs past its halfway mark. The second fires when a byte arrives while no room is left. The third fires when a packet-closing byte is stored. The fourth fires when the entry that the next read will return closes a packet. That fourth pulse also fires when the host reads from an empty queue, so the host learns that its read found no data.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `level` is 0, all four event outputs are 0, and `rd_data`/`rd_eop` are 0.
- R2: Bytes come out in the order they were accepted, each with the flag it was written with. The value of a read appears on `rd_data`/`rd_eop` in the cycle after the clock edge that sampled `rd_en`, and it holds until the next read.
- R3: A write while 32 entries are held and no read is requested is discarded. `evt_ovf` is high for exactly the one cycle after that edge, and `level` stays 32.
- R4: A write and a read in the same cycle while full both take effect. `evt_ovf` stays low, `level` stays 32, and the new byte is later read in order.
- R5: `evt_thresh` pulses for one cycle when `level` moves from 16 to 17, and at no other time (not on 17 to 18, nor while it holds at 17).
- R6: `evt_eop_wr` pulses for one cycle after an accepted write with `wr_eop`=1. A discarded write does not raise it.
- R7: `evt_head_last` is high for one cycle whenever a flagged entry becomes the head. This happens when a flagged byte is written into an empty queue, or when a read exposes a flagged entry. The pulse is visible in the cycle after the causing edge.
- R8: A read while empty returns `rd_data`=0 and `rd_eop`=0, moves no pointer, and raises `evt_head_last` in the following cycle. A write in that same cycle is still accepted.
- R9: `level` equals the number of stored entries, never exceeds 32, and changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_data | input | 8 | Byte to store |
| wr_eop | input | 1 | Byte closes a packet |
| rd_en | input | 1 | Read strobe from the host |
| rd_data | output | 8 | Byte returned by the last read |
| rd_eop | output | 1 | Flag of the byte returned by the last read |
| level | output | 6 | Number of stored entries (0 to 32) |
| evt_thresh | output | 1 | Fill rose from 16 to 17 |
| evt_ovf | output | 1 | A write was discarded because the queue was full |
| evt_eop_wr | output | 1 | A packet-closing byte was stored |
| evt_head_last | output | 1 | Head entry closes a packet, or a read found the queue empty |

## Verification
The corners that are hardest to reach from the ports are at the full boundary. There, a discarded write carrying a closing flag must leave no trace, while a write paired with a read must slip in without an overflow pulse. Both cases need the queue filled to exactly 32 with a known flag pattern first. The stimulus writes 32 bytes with a flag on every fifth one, passing through 16 to 17 on the way. It then tries a flagged write at full, follows with a paired read and write, and drains the queue past empty so that reads on an empty queue, with and without a same-cycle write, are also covered. A long interleaved phase then moves the head across every flag position and wraps the pointers several times.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
  localparam int HRF_DW = 8;

  typedef struct packed {
    logic              last;
    logic [HRF_DW-1:0] data;
  } hrf_entry_t;

  localparam int HRF_EW = $bits(hrf_entry_t);
endpackage

// File: rtl/hrf_store.sv
module hrf_store
  import hrf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        we,
  input  logic [AW-1:0] waddr,
  input  hrf_entry_t  wentry,
  input  logic [AW-1:0] raddr,
  output hrf_entry_t  rentry
);
  hrf_entry_t slot_q [DEPTH];

  // One register per slot, each with its own write enable.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = we && (waddr == AW'(g));
    always_ff @(posedge clk) begin
      if (hit) slot_q[g] <= wentry;
    end
  end

  assign rentry = slot_q[raddr];
endmodule

// File: rtl/hrf_ctrl.sv
module hrf_ctrl #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          push,
  output logic          pop,
  output logic          rd_on_empty,
  output logic          wr_dropped,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] level,
  output logic          empty,
  output logic          full
);
  localparam logic [PW-1:0] FULL_L = PW'(DEPTH);

  // The pointers carry one extra wrap bit, so a full queue and an empty one have different levels.
  function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p);
    return p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] fill_of(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return w - r;
  endfunction

  logic [PW-1:0] wr_ptr_q, rd_ptr_q;

  assign level = fill_of(wr_ptr_q, rd_ptr_q);
  assign empty = (level == '0);
  assign full  = (level == FULL_L);

  // A read frees a slot in the same cycle, so a write paired with a read is accepted even when full.
  assign pop         = rd_req && !empty;
  assign push        = wr_req && (!full || rd_req);
  assign rd_on_empty = rd_req && empty;
  assign wr_dropped  = wr_req && full && !rd_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push) wr_ptr_q <= ptr_step(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_step(rd_ptr_q);
    end
  end

  assign wr_ptr = wr_ptr_q;
  assign rd_ptr = rd_ptr_q;
endmodule

// File: rtl/hrf_events.sv
module hrf_events #(
  parameter int DEPTH  = 32,
  parameter int THRESH = 16,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          wr_last,
  input  logic          wr_dropped,
  input  logic          rd_on_empty,
  input  logic [PW-1:0] level,
  input  logic [PW-1:0] rd_ptr,
  input  logic          empty,
  input  logic          head_last,
  output logic          evt_thresh,
  output logic          evt_ovf,
  output logic          evt_eop_wr,
  output logic          evt_head_last
);
  localparam logic [PW-1:0] THR_L  = PW'(THRESH);
  localparam logic [PW-1:0] THR1_L = PW'(THRESH + 1);

  function automatic logic [PW-1:0] level_after(input logic [PW-1:0] l, input logic in_b,
                                               input logic out_b);
    return (l + {{(PW-1){1'b0}}, in_b}) - {{(PW-1){1'b0}}, out_b};
  endfunction

  function automatic logic crosses_up(input logic [PW-1:0] now_l, input logic [PW-1:0] nxt_l);
    return (now_l == THR_L) && (nxt_l == THR1_L);
  endfunction

  logic          thr_q, ovf_q, eopw_q, rde_q;
  logic          prev_empty_q;
  logic [PW-1:0] prev_rd_ptr_q;
  logic [PW-1:0] level_nxt;
  logic          head_moved;
  logic          head_arrive;

  assign level_nxt = level_after(level, push, pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q         <= 1'b0;
      ovf_q         <= 1'b0;
      eopw_q        <= 1'b0;
      rde_q         <= 1'b0;
      prev_empty_q  <= 1'b1;
      prev_rd_ptr_q <= '0;
    end else begin
      thr_q         <= crosses_up(level, level_nxt);
      ovf_q         <= wr_dropped;
      eopw_q        <= push && wr_last;
      rde_q         <= rd_on_empty;
      prev_empty_q  <= empty;
      prev_rd_ptr_q <= rd_ptr;
    end
  end

  // The head entry is new when the queue was empty one cycle ago, or when the read pointer has moved since then.
  assign head_moved  = prev_empty_q || (rd_ptr != prev_rd_ptr_q);
  assign head_arrive = !empty && head_last && head_moved;

  assign evt_thresh    = thr_q;
  assign evt_ovf       = ovf_q;
  assign evt_eop_wr    = eopw_q;
  assign evt_head_last = head_arrive || rde_q;
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
  import hrf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int THRESH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [HRF_DW-1:0] wr_data,
  input  logic              wr_eop,
  input  logic              rd_en,
  output logic [HRF_DW-1:0] rd_data,
  output logic              rd_eop,
  output logic [PW-1:0]     level,
  output logic              evt_thresh,
  output logic              evt_ovf,
  output logic              evt_eop_wr,
  output logic              evt_head_last
);
  logic          push, pop, rd_on_empty, wr_dropped, empty, full;
  logic [PW-1:0] wr_ptr, rd_ptr;
  hrf_entry_t    head, wentry, out_q;

  assign wentry = '{last: wr_eop, data: wr_data};

  hrf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_req      (wr_en),
    .rd_req      (rd_en),
    .push        (push),
    .pop         (pop),
    .rd_on_empty (rd_on_empty),
    .wr_dropped  (wr_dropped),
    .wr_ptr      (wr_ptr),
    .rd_ptr      (rd_ptr),
    .level       (level),
    .empty       (empty),
    .full        (full)
  );

  hrf_store #(.DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .we     (push),
    .waddr  (wr_ptr[AW-1:0]),
    .wentry (wentry),
    .raddr  (rd_ptr[AW-1:0]),
    .rentry (head)
  );

  hrf_events #(.DEPTH(DEPTH), .THRESH(THRESH)) u_events (
    .clk           (clk),
    .rst_n         (rst_n),
    .push          (push),
    .pop           (pop),
    .wr_last       (wr_eop),
    .wr_dropped    (wr_dropped),
    .rd_on_empty   (rd_on_empty),
    .level         (level),
    .rd_ptr        (rd_ptr),
    .empty         (empty),
    .head_last     (head.last),
    .evt_thresh    (evt_thresh),
    .evt_ovf       (evt_ovf),
    .evt_eop_wr    (evt_eop_wr),
    .evt_head_last (evt_head_last)
  );

  // The read register takes the head entry on a pop and zero on a read from an empty queue; otherwise it holds.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (rd_en) begin
      out_q <= pop ? head : '0;
    end
  end

  assign rd_data = out_q.data;
  assign rd_eop  = out_q.last;

  logic unused_full;
  assign unused_full = full;
endmodule

// File: rtl/hrf_chk.sv
module hrf_chk #(
  parameter int DEPTH  = 32,
  parameter int THRESH = 16,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_eop,
  input logic          rd_en,
  input logic [7:0]    rd_data,
  input logic          rd_eop,
  input logic [PW-1:0] level,
  input logic          evt_thresh,
  input logic          evt_ovf,
  input logic          evt_eop_wr,
  input logic          evt_head_last,
  input logic          push,
  input logic          pop
);
  localparam logic [PW-1:0] FULL_L = PW'(DEPTH);
  localparam logic [PW-1:0] THR_L  = PW'(THRESH);
  localparam logic [PW-1:0] THR1_L = PW'(THRESH + 1);

  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_L);

  // R9
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level == (($past(level) + {{(PW-1){1'b0}}, $past(push)}) - {{(PW-1){1'b0}}, $past(pop)}));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |-> (level == FULL_L) && $past(wr_en && !rd_en));

  // R4
  full_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && rd_en && (level == FULL_L)) |-> !evt_ovf && (level == FULL_L));

  // R5
  thresh_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_thresh |-> (level == THR1_L) && ($past(level) == THR_L));

  // R6
  eop_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_eop_wr |-> $past(push && wr_eop));

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && (level == '0)) |-> evt_head_last && (rd_data == 8'h00) && !rd_eop);
endmodule

bind hdlc_rx_fifo hrf_chk #(.DEPTH(DEPTH), .THRESH(THRESH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_eop        (wr_eop),
  .rd_en         (rd_en),
  .rd_data       (rd_data),
  .rd_eop        (rd_eop),
  .level         (level),
  .evt_thresh    (evt_thresh),
  .evt_ovf       (evt_ovf),
  .evt_eop_wr    (evt_eop_wr),
  .evt_head_last (evt_head_last),
  .push          (push),
  .pop           (pop)
);

// File: tb/tb_hdlc_rx_fifo.sv
module tb_hdlc_rx_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_eop = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rd_eop;
  logic [5:0] level;
  logic       evt_thresh, evt_ovf, evt_eop_wr, evt_head_last;

  int n_chk = 0;
  int n_fail = 0;
  logic [8:0] sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_fifo dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_eop(wr_eop),
    .rd_en(rd_en), .rd_data(rd_data), .rd_eop(rd_eop), .level(level),
    .evt_thresh(evt_thresh), .evt_ovf(evt_ovf), .evt_eop_wr(evt_eop_wr),
    .evt_head_last(evt_head_last)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Driver: one call holds the inputs for exactly one rising edge.
  task automatic drive(input logic we, input logic [7:0] wd, input logic weop, input logic re);
    @(negedge clk);
    wr_en = we; wr_data = wd; wr_eop = weop; rd_en = re;
  endtask

  task automatic idle();
    drive(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  // Monitor/scoreboard: the reference model advances at each edge, and the outputs are compared 2 time units later.
  always @(posedge clk) begin
    if (rst_n) begin
      automatic logic we = wr_en, re = rd_en, weop = wr_eop;
      automatic logic [7:0] wd = wr_data;
      automatic int old_l = sb_q.size();
      automatic logic was_full = (old_l == CAP);
      automatic logic was_empty = (old_l == 0);
      automatic logic do_pop = re && !was_empty;
      automatic logic do_push = we && (!was_full || re);
      automatic logic [8:0] got_exp = 9'h000;
      automatic logic e_ovf, e_eopw, e_thr, e_head;
      automatic int new_l;
      if (do_pop) got_exp = sb_q.pop_front();
      if (do_push) sb_q.push_back({weop, wd});
      new_l  = sb_q.size();
      e_ovf  = we && was_full && !re;
      e_eopw = do_push && weop;
      e_thr  = (old_l == 16) && (new_l == 17);
      e_head = ((new_l > 0) && sb_q[0][8] && (do_pop || was_empty)) || (re && was_empty);
      #2;
      if (re) begin
        check("R2", "rd_data", 32'(rd_data), 32'(got_exp[7:0]));
        check("R2", "rd_eop", 32'(rd_eop), 32'(got_exp[8]));
      end
      check("R9", "level", 32'(level), 32'(new_l));
      check("R3", "evt_ovf", 32'(evt_ovf), 32'(e_ovf));
      check("R6", "evt_eop_wr", 32'(evt_eop_wr), 32'(e_eopw));
      check("R5", "evt_thresh", 32'(evt_thresh), 32'(e_thr));
      check("R7", "evt_head_last", 32'(evt_head_last), 32'(e_head));
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    automatic logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    #1;
    // R1: state during reset
    check("R1", "reset level", 32'(level), 0);
    check("R1", "reset events", 32'({evt_thresh, evt_ovf, evt_eop_wr, evt_head_last}), 0);
    check("R1", "reset rd_data", 32'({rd_eop, rd_data}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Short packet, then read it back.
    drive(1, 8'h11, 0, 0);
    drive(1, 8'h22, 0, 0);
    drive(1, 8'h33, 1, 0);
    repeat (3) drive(0, 8'h00, 0, 1);
    idle();

    // Fill to 32 with a flag on every fifth byte (passes 16 -> 17).
    for (int i = 0; i < CAP; i++) drive(1, 8'(i * 7 + 1), (i % 5) == 4, 0);
    // R3, R6: a flagged write at full is dropped
    drive(1, 8'hEE, 1, 0);
    // R4: paired read and write at full
    drive(1, 8'hAB, 1, 1);
    @(posedge clk);
    #3;
    check("R4", "level after full rw", 32'(level), CAP);
    check("R4", "evt_ovf after full rw", 32'(evt_ovf), 0);

    // Drain everything, then read an empty queue.
    for (int i = 0; i < CAP; i++) drive(0, 8'h00, 0, 1);
    drive(0, 8'h00, 0, 1);
    @(posedge clk);
    #3;
    // R8: read while empty
    check("R8", "empty read data", 32'({rd_eop, rd_data}), 0);
    check("R8", "empty read level", 32'(level), 0);
    check("R8", "empty read event", 32'(evt_head_last), 1);
    // R8: read on empty together with a flagged write
    drive(1, 8'h5A, 1, 1);
    idle();
    drive(0, 8'h00, 0, 1);
    idle();

    // Interleaved traffic from a 16-bit LFSR.
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0] | lfsr[5], lfsr[15:8], lfsr[3] & lfsr[6], lfsr[1] & (lfsr[2] | (i > 1000)));
    end
    for (int i = 0; i < CAP + 2; i++) drive(0, 8'h00, 0, 1);
    idle();
    repeat (3) @(posedge clk);
    #3;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule